// File: doc/BRIEF.md
# Interrupt context save sequencer

When the core accepts an interrupt, this block stores the return context on a byte-wide stack in memory. It captures the 20-bit program counter and the 16-bit flag word at the acknowledge. It also picks one of two stack pointers. It then drives four byte writes, one per clock, to the four addresses just below that pointer.

The top byte combines two things: the four priority-level bits from the top of the flag word and the four top program-counter bits. Below it are the low flag byte and then the two low program-counter bytes. Software interrupts numbered 32 through 63 use the stack that the user-stack flag selects. Every other interrupt uses the interrupt stack.

When the fourth write is done, the block raises a one-cycle done pulse. With it, the block gives the new pointer value (four below the old one) and says which of the two pointers to write it into.

Top module: `ctx_push_seq`

## Requirements
- R1: After a synchronous active-high reset, `wr_en_o`, `busy_o` and `done_o` are low. They stay low until an acknowledge is seen after reset ends.
- R2: An acknowledge seen while idle starts four writes, one per clock, in the four cycles right after the acknowledge edge. The addresses run SP-1, SP-2, SP-3, SP-4, where SP is the selected pointer at the acknowledge.
- R3: The byte written to SP-1 has the flag word's bits 15:12 (priority level) in bits 7:4 and program-counter bits 19:16 in bits 3:0.
- R4: SP-2 receives flag bits 7:0. SP-3 receives program-counter bits 15:8. SP-4 receives program-counter bits 7:0.
- R5: The user pointer is selected when the interrupt number is from 32 to 63 and `usr_flag_i` is 1. In every other case the interrupt pointer is selected. `sp_is_user_o` is 1 when the user pointer was used.
- R6: `done_o` is high for exactly one cycle, the cycle after the fourth write. In that cycle `sp_new_o` equals the selected pointer minus 4, and no write is active.
- R7: `busy_o` is high from the first write cycle through the done cycle. It is low in the cycle after done.
- R8: An acknowledge during a save is ignored. Changes to the context inputs after the acknowledge edge do not affect the written bytes, the addresses or the returned pointer.
- R9: Address and pointer arithmetic wraps modulo 2^16. For example, SP=2 writes to 0x0001, 0x0000, 0xFFFF and 0xFFFE and returns 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ack_i | input | 1 | Interrupt acknowledge, sampled while idle |
| vec_i | input | 8 | Interrupt number |
| pc_i | input | 20 | Program counter to save |
| flg_i | input | 16 | Flag word; bits 15:12 hold the priority level |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| usr_flag_i | input | 1 | Stack-select flag |
| wr_en_o | output | 1 | Byte write strobe |
| wr_addr_o | output | 16 | Byte write address |
| wr_data_o | output | 8 | Byte write data |
| busy_o | output | 1 | Save in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_new_o | output | 16 | Updated pointer, valid with done_o |
| sp_is_user_o | output | 1 | 1: update the user pointer; 0: the interrupt pointer |

## Verification
A wrong write index or a stuck sequencer state shows up at the first write after an acknowledge. Either the address or the data byte is wrong, or the fourth write or the done pulse lands in the wrong cycle, so the fault is visible within five cycles. A wrong capture of the pointer or the context appears as wrong addresses or bytes in that same save, or as a wrong `sp_new_o` at done. A stack-select error shows up only for interrupt numbers near 31/32 and 63/64, so those boundaries get directed cases next to the random ones.

// File: rtl/ctx_push_pkg.sv
package ctx_push_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PUSH = 2'd1,
      ST_DONE = 2'd2
   } push_state_e;
endpackage

// File: rtl/ctx_stack_select.sv
module ctx_stack_select #(
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 16,
   parameter int SW_LO  = 32,
   parameter int SW_HI  = 63
) (
   input  logic [VEC_W-1:0]  vec_i,
   input  logic [ADDR_W-1:0] isp_i,
   input  logic [ADDR_W-1:0] usp_i,
   input  logic              usr_flag_i,
   output logic [ADDR_W-1:0] sp_o,
   output logic              is_user_o
);
   localparam int VEC_MAX = (1 << VEC_W) - 1;

   generate
      if (SW_LO > SW_HI) begin : g_bad_range
         $error("ctx_stack_select: SW_LO must not exceed SW_HI");
      end
      if (SW_LO > VEC_MAX) begin : g_bad_width
         $error("ctx_stack_select: VEC_W too narrow for the software range");
      end
   endgenerate

   logic in_sw_range;

   always_comb begin
      in_sw_range = (int'(vec_i) >= SW_LO) && (int'(vec_i) <= SW_HI);
      is_user_o   = in_sw_range && usr_flag_i;
      sp_o        = is_user_o ? usp_i : isp_i;
   end
endmodule

// File: rtl/ctx_byte_pack.sv
module ctx_byte_pack #(
   parameter int PC_W          = 20,
   parameter int FLG_W         = 16,
   parameter int DATA_W        = 8,
   parameter int N_BYTES       = 4,
   parameter bit LEVEL_IN_HIGH = 1'b1
) (
   input  logic [PC_W-1:0]   pc_i,
   input  logic [FLG_W-1:0]  flg_i,
   output logic [N_BYTES-1:0][DATA_W-1:0] bytes_o
);
   localparam int PC_HI_W = PC_W - 2 * DATA_W;
   localparam int LVL_W   = DATA_W - PC_HI_W;

   generate
      if (PC_HI_W <= 0 || LVL_W <= 0) begin : g_bad_pc
         $error("ctx_byte_pack: upper PC bits must fit beside the level in one byte");
      end
      if (FLG_W != 2 * DATA_W) begin : g_bad_flg
         $error("ctx_byte_pack: flag word must be two bytes");
      end
      if (N_BYTES != 4) begin : g_bad_n
         $error("ctx_byte_pack: frame is four bytes");
      end
   endgenerate

   logic [PC_HI_W-1:0] pc_hi;
   logic [LVL_W-1:0]   level;
   logic [DATA_W-1:0]  mixed;

   assign pc_hi = pc_i[PC_W-1 -: PC_HI_W];
   assign level = flg_i[FLG_W-1 -: LVL_W];

   generate
      if (LEVEL_IN_HIGH) begin : g_lvl_hi
         assign mixed = {level, pc_hi};
      end else begin : g_lvl_lo
         assign mixed = {pc_hi, level};
      end
   endgenerate

   assign bytes_o[0] = mixed;
   assign bytes_o[1] = flg_i[DATA_W-1:0];
   assign bytes_o[2] = pc_i[2*DATA_W-1:DATA_W];
   assign bytes_o[3] = pc_i[DATA_W-1:0];
endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
   import ctx_push_pkg::*;
#(
   parameter int N_BYTES = 4,
   localparam int IDX_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   output logic             load_o,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             busy_o,
   output logic             done_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

   push_state_e      state_q;
   logic [IDX_W-1:0] idx_q;

   assign load_o = (state_q == ST_IDLE) && start_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               idx_q <= '0;
               if (start_i) state_q <= ST_PUSH;
            end
            ST_PUSH: begin
               if (idx_q == LAST_IDX) begin
                  state_q <= ST_DONE;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_en_o = (state_q == ST_PUSH);
   assign idx_o   = idx_q;
   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/ctx_push_seq.sv
module ctx_push_seq
   import ctx_push_pkg::*;
#(
   parameter int PC_W    = 20,
   parameter int FLG_W   = 16,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int VEC_W   = 8,
   parameter int SW_LO   = 32,
   parameter int SW_HI   = 63,
   parameter bit LEVEL_IN_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ack_i,
   input  logic [VEC_W-1:0]  vec_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [FLG_W-1:0]  flg_i,
   input  logic [ADDR_W-1:0] isp_i,
   input  logic [ADDR_W-1:0] usp_i,
   input  logic              usr_flag_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] sp_new_o,
   output logic              sp_is_user_o
);
   localparam int N_BYTES = 4;
   localparam int IDX_W   = $clog2(N_BYTES);

   logic              load;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] sel_sp;
   logic              sel_user;
   logic [ADDR_W-1:0] sp_q;
   logic              user_q;
   logic [PC_W-1:0]   pc_q;
   logic [FLG_W-1:0]  flg_q;
   logic [N_BYTES-1:0][DATA_W-1:0] frame;

   ctx_stack_select #(
      .VEC_W(VEC_W), .ADDR_W(ADDR_W), .SW_LO(SW_LO), .SW_HI(SW_HI)
   ) i_sel (
      .vec_i(vec_i), .isp_i(isp_i), .usp_i(usp_i), .usr_flag_i(usr_flag_i),
      .sp_o(sel_sp), .is_user_o(sel_user)
   );

   ctx_seq_fsm #(.N_BYTES(N_BYTES)) i_fsm (
      .clk(clk), .rst(rst), .start_i(ack_i), .load_o(load),
      .wr_en_o(wr_en_o), .idx_o(idx), .busy_o(busy_o), .done_o(done_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sp_q   <= '0;
         user_q <= 1'b0;
         pc_q   <= '0;
         flg_q  <= '0;
      end else if (load) begin
         sp_q   <= sel_sp;
         user_q <= sel_user;
         pc_q   <= pc_i;
         flg_q  <= flg_i;
      end
   end

   ctx_byte_pack #(
      .PC_W(PC_W), .FLG_W(FLG_W), .DATA_W(DATA_W), .N_BYTES(N_BYTES),
      .LEVEL_IN_HIGH(LEVEL_IN_HIGH)
   ) i_pack (
      .pc_i(pc_q), .flg_i(flg_q), .bytes_o(frame)
   );

   assign wr_addr_o    = sp_q - ADDR_W'(idx) - ADDR_W'(1);
   assign wr_data_o    = frame[idx];
   assign sp_new_o     = sp_q - ADDR_W'(N_BYTES);
   assign sp_is_user_o = user_q;
endmodule

// File: rtl/ctx_push_seq_chk.sv
module ctx_push_seq_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic              busy_o,
   input logic              done_o,
   input logic [ADDR_W-1:0] sp_new_o
);
   // R1: reset clears activity on the next cycle
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (!wr_en_o && !busy_o && !done_o));

   // R2: consecutive writes step down by one address
   a_r2_descending: assert property (@(posedge clk) disable iff (rst)
      (wr_en_o && $past(wr_en_o) && !$past(rst)) |-> (wr_addr_o == $past(wr_addr_o) - 1'b1));

   // R6: done never overlaps a write and lasts one cycle
   a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
      $onehot0({wr_en_o, done_o}));
   a_r6_single: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
   a_r6_after_write: assert property (@(posedge clk) disable iff (rst)
      done_o |-> $past(wr_en_o));
   // R6 with R9: returned pointer is the last written address
   a_r6_new_sp: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (sp_new_o == $past(wr_addr_o)));

   // R7: busy covers writes and is released after done
   a_r7_busy_cover: assert property (@(posedge clk) disable iff (rst)
      (wr_en_o || done_o) |-> busy_o);
   a_r7_release: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !busy_o);
endmodule

bind ctx_push_seq ctx_push_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst(rst), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
   .busy_o(busy_o), .done_o(done_o), .sp_new_o(sp_new_o)
);

// File: tb/test_ctx_push_seq.sv
module test_ctx_push_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        ack_i;
   logic [7:0]  vec_i;
   logic [19:0] pc_i;
   logic [15:0] flg_i;
   logic [15:0] isp_i;
   logic [15:0] usp_i;
   logic        usr_flag_i;
   logic        wr_en_o;
   logic [15:0] wr_addr_o;
   logic [7:0]  wr_data_o;
   logic        busy_o;
   logic        done_o;
   logic [15:0] sp_new_o;
   logic        sp_is_user_o;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctx_push_seq i_ctx_push_seq (
      .clk(clk), .rst(rst), .ack_i(ack_i), .vec_i(vec_i), .pc_i(pc_i),
      .flg_i(flg_i), .isp_i(isp_i), .usp_i(usp_i), .usr_flag_i(usr_flag_i),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .busy_o(busy_o), .done_o(done_o), .sp_new_o(sp_new_o),
      .sp_is_user_o(sp_is_user_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_user(input logic [7:0] v, input logic u);
      return (v >= 8'd32) && (v <= 8'd63) && u;
   endfunction

   function automatic logic [7:0] exp_byte(input int k, input logic [19:0] pc, input logic [15:0] fl);
      case (k)
         0:       return {fl[15:12], pc[19:16]};
         1:       return fl[7:0];
         2:       return pc[15:8];
         default: return pc[7:0];
      endcase
   endfunction

   task automatic do_save(input logic [7:0] v, input logic [19:0] pc, input logic [15:0] fl,
                          input logic [15:0] isp, input logic [15:0] usp, input logic u,
                          input bit poke);
      logic [15:0] sp;
      bit          usr;
      usr = exp_user(v, u);
      sp  = usr ? usp : isp;
      @(negedge clk);
      vec_i = v; pc_i = pc; flg_i = fl; isp_i = isp; usp_i = usp; usr_flag_i = u;
      ack_i = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         check("R2 wr_en", 32'(wr_en_o), 32'd1);
         check("R2/R9 addr", 32'(wr_addr_o), 32'(16'(sp - 16'(k + 1))));
         if (k == 0) check("R3 mixed byte", 32'(wr_data_o), 32'(exp_byte(k, pc, fl)));
         else        check("R4 data byte", 32'(wr_data_o), 32'(exp_byte(k, pc, fl)));
         check("R7 busy", 32'(busy_o), 32'd1);
         if (poke) begin
            // R8: new acknowledge and changed context during the save
            ack_i = 1'b1; pc_i = ~pc; flg_i = ~fl; isp_i = isp ^ 16'h5a5a;
            usp_i = usp ^ 16'ha5a5; vec_i = v ^ 8'h20; usr_flag_i = ~u;
         end else begin
            ack_i = 1'b0;
         end
         @(negedge clk);
      end
      check("R6 done", 32'(done_o), 32'd1);
      check("R6 no write", 32'(wr_en_o), 32'd0);
      check("R6/R9 sp_new", 32'(sp_new_o), 32'(16'(sp - 16'd4)));
      check("R5 stack", 32'(sp_is_user_o), 32'(usr));
      check("R7 busy at done", 32'(busy_o), 32'd1);
      ack_i = poke ? 1'b1 : 1'b0;
      @(negedge clk);
      check("R7 release", 32'(busy_o), 32'd0);
      check("R6 pulse", 32'(done_o), 32'd0);
      if (poke) check("R8 ack ignored", 32'(wr_en_o), 32'd0);
      ack_i = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd20250;
      void'($urandom(seed));
      rst = 1'b1; ack_i = 1'b1; vec_i = '0; pc_i = '0; flg_i = '0;
      isp_i = 16'h1000; usp_i = 16'h2000; usr_flag_i = 1'b0;
      repeat (3) @(negedge clk);
      ack_i = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      check("R1 wr_en", 32'(wr_en_o), 32'd0);
      check("R1 busy", 32'(busy_o), 32'd0);
      check("R1 done", 32'(done_o), 32'd0);

      // directed: vector boundaries for R5
      do_save(8'd31, 20'hABCDE, 16'h7F35, 16'h0800, 16'h0400, 1'b1, 1'b0);
      do_save(8'd32, 20'h12345, 16'h3C81, 16'h0800, 16'h0400, 1'b1, 1'b0);
      do_save(8'd63, 20'hF0F0F, 16'hE00F, 16'h0800, 16'h0400, 1'b1, 1'b0);
      do_save(8'd64, 20'h0FFFF, 16'h1234, 16'h0800, 16'h0400, 1'b1, 1'b0);
      do_save(8'd40, 20'h55AA3, 16'h9966, 16'h0800, 16'h0400, 1'b0, 1'b0);
      // R9: wrap below zero
      do_save(8'd5, 20'h80001, 16'hF0FF, 16'h0002, 16'h0400, 1'b0, 1'b0);
      do_save(8'd50, 20'h00000, 16'h0000, 16'h0800, 16'h0000, 1'b1, 1'b0);
      // R8: disturbances during the save
      do_save(8'd10, 20'h2468A, 16'hB5C3, 16'h3000, 16'h4000, 1'b0, 1'b1);
      do_save(8'd33, 20'hFEDCB, 16'h4A5B, 16'h3000, 16'h4000, 1'b1, 1'b1);

      for (int i = 0; i < 40; i++) begin
         logic [7:0] v;
         v = 8'($urandom_range(0, 95));
         do_save(v, 20'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                 1'($urandom), 1'($urandom_range(0, 3) == 0));
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule